// File: doc/BRIEF.md
# Sequential Booth Multiplier

This block multiplies two signed 32-bit operands and returns their full 64-bit two's-complement product. It takes several clock cycles per operation: it handles one multiplier bit per cycle, using a single double-width shift register and one adder/subtractor. The multiplier starts out in the low half of the shift register and drains out of it as the product builds up in the high half. No sign correction is needed at the end, because Booth recoding takes care of negative operands.

The block uses a request/acknowledge scheme with plain control pins. The block is ready when `busy` is low. A request is `start` high during such a cycle, and the operands only need to be valid in that cycle. Requests that arrive while `busy` is high are dropped; they are not queued. The result side has no back-pressure. `done` pulses for one cycle when the product is final, and `product` then keeps that value until the next accepted request.

Each step looks at the lowest bit of the shift register together with the bit that was shifted out in the previous step. A rising edge of the pair (current 0, previous 1) adds the multiplicand to the upper half. A falling edge (current 1, previous 0) subtracts it. Equal bits leave the upper half unchanged. After this the register shifts right by one, and the shifted-in bit is the sign of the add/subtract result.

Top module: `booth_mul_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `done` and `product` are all zero.
- R2: When `start` is high and `busy` is low at a rising edge, `busy` is high for exactly 32 cycles starting at the next edge.
- R3: `done` is high for one cycle only, in the cycle right after the last busy cycle. `done` never goes high without a completed operation.
- R4: When `done` is high, `product` equals the signed 64-bit product of the `mcand` and `mplier` values sampled at the accepting edge.
- R5: A `start` that arrives while `busy` is high is ignored. The running operation keeps its operands, its length and its result.
- R6: The most negative operand value (0x80000000) gives the correct product whichever input carries it, including when it is multiplied by itself, by -1 or by the largest positive value. A zero operand gives zero.
- R7: While `busy` is low and no request is accepted, `product` and `busy` keep their values.
- R8: The operand inputs may change freely after the accepting edge without affecting the result.
- R9: Small operands give exact results for both signs, for example 2 × 6 = 12 and -7 × 3 = -21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiply; only takes effect while `busy` is low |
| mcand | input | 32 | Multiplicand, signed; sampled when a request is accepted |
| mplier | input | 32 | Multiplier, signed; sampled when a request is accepted |
| busy | output | 1 | High while an operation is in progress (block not ready) |
| done | output | 1 | One-cycle pulse: the product is final |
| product | output | 64 | Signed product register; valid from `done` until the next accept |

## Verification
The assertions check the control timing on every cycle: the exact 32-cycle busy window, the fact that a request during busy neither shortens nor restarts that window, the single-cycle `done` pulse, and a stable product while idle. They cannot tell whether the arithmetic is correct. The correctness of the product comes only from the bench scenarios, which compare against a signed reference multiply. These scenarios cover the most negative operand in each position, zero operands, mixed signs, operands scrambled after acceptance, and a second request injected in the middle of an operation.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // Action chosen by one recoding step
  typedef enum logic [1:0] {
    BOOTH_HOLD = 2'd0,
    BOOTH_ADD  = 2'd1,
    BOOTH_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      prev_bit,
  output booth_op_e op
);
  // pair {cur,prev}: 10 starts a run of ones, 01 ends one
  always_comb begin
    unique case ({cur_bit, prev_bit})
      2'b10:   op = BOOTH_SUB;
      2'b01:   op = BOOTH_ADD;
      default: op = BOOTH_HOLD;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0] acc,
  input  logic [OP_W-1:0] addend,
  input  booth_op_e       op,
  output logic [OP_W:0]   sum
);
  localparam int EXT_W = OP_W + 1;

  logic [EXT_W-1:0] acc_x;
  logic [EXT_W-1:0] add_x;

  // one guard bit keeps the true sign when the magnitude reaches 2^(OP_W-1)
  assign acc_x = {acc[OP_W-1], acc};
  assign add_x = {addend[OP_W-1], addend};

  always_comb begin
    unique case (op)
      BOOTH_ADD: sum = acc_x + add_x;
      BOOTH_SUB: sum = acc_x + ~add_x + EXT_W'(1);
      default:   sum = acc_x;
    endcase
  end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic accept,
  output logic step_en,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;
  logic             last_step;

  assign accept    = start & ~busy_q;
  assign step_en   = busy_q;
  assign last_step = busy_q & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= last_step;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (last_step) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
  import booth_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   mcand,
  input  logic [OP_W-1:0]   mplier,
  output logic              busy,
  output logic              done,
  output logic [2*OP_W-1:0] product
);
  localparam int PROD_W = 2 * OP_W;

  logic [PROD_W-1:0] prod_q;
  logic [OP_W-1:0]   mcand_q;
  logic              prev_q;
  logic              accept;
  logic              step_en;
  booth_op_e         step_op;
  logic [OP_W:0]     step_sum;

  booth_seq_ctrl #(.STEPS(OP_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .accept  (accept),
    .step_en (step_en),
    .busy    (busy),
    .done    (done)
  );

  booth_recode u_recode (
    .cur_bit  (prod_q[0]),
    .prev_bit (prev_q),
    .op       (step_op)
  );

  booth_addsub #(.OP_W(OP_W)) u_addsub (
    .acc    (prod_q[PROD_W-1:OP_W]),
    .addend (mcand_q),
    .op     (step_op),
    .sum    (step_sum)
  );

  // The upper half takes the add/subtract result. Then the whole register
  // shifts right once, and the guard bit of the sum is the bit shifted in.
  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q  <= '0;
      mcand_q <= '0;
      prev_q  <= 1'b0;
    end else if (accept) begin
      prod_q  <= {{OP_W{1'b0}}, mplier};
      mcand_q <= mcand;
      prev_q  <= 1'b0;
    end else if (step_en) begin
      prod_q  <= {step_sum, prod_q[OP_W-1:1]};
      prev_q  <= prod_q[0];
    end
  end

  assign product = prod_q;
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int OP_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [2*OP_W-1:0] product
);
  localparam int RUN_W = $clog2(OP_W) + 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(OP_W - 1);

  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_cnt <= '0;
    else              run_cnt <= run_cnt + RUN_W'(1);
  end

  AST_ACCEPT_RISES: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && !done)); // R2

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && run_cnt != RUN_LAST) |=> busy); // R5

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
    (busy && run_cnt == RUN_LAST) |=> (!busy && done)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> (!busy && $stable(product))); // R7
endmodule

bind booth_mul_seq booth_mul_chk #(.OP_W(OP_W)) u_booth_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/test_booth_mul_seq.sv
module test_booth_mul_seq;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic          busy;
  logic          done;
  logic [63:0]   product;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;
  logic cmp_on = 1'b0;

  always #4 clk = ~clk;

  booth_mul_seq #(.OP_W(W)) i_booth_mul_seq (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [63:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [63:0] x;
    logic signed [63:0] y;
    x = {{(64-W){a[W-1]}}, a};
    y = {{(64-W){b[W-1]}}, b};
    return x * y;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: operation count, cycle count, result
  logic        m_busy = 1'b0;
  logic        m_done = 1'b0;
  logic [63:0] m_prod = '0;
  int          m_cnt = 0;
  logic [W-1:0] m_a = '0;
  logic [W-1:0] m_b = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_prod <= '0; m_cnt <= 0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy && start) begin
        m_busy <= 1'b1; m_cnt <= 0; m_a <= mcand; m_b <= mplier;
      end else if (m_busy) begin
        if (m_cnt == W - 1) begin
          m_busy <= 1'b0; m_done <= 1'b1; m_prod <= ref_mul(m_a, m_b);
        end else begin
          m_cnt <= m_cnt + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(busy == m_busy, "R2 busy", 64'(busy), 64'(m_busy));
      chk(done == m_done, "R3 done", 64'(done), 64'(m_done));
      if (!m_busy) begin
        if (m_done) chk(product == m_prod, "R4 product at done", product, m_prod);
        else        chk(product == m_prod, "R7 idle product", product, m_prod);
      end
    end
  end

  // issue one request, scramble operands afterwards (R8), wait for done
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [63:0] exp, input string tag);
    while (busy) @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0; mcand = $urandom; mplier = $urandom;
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    chk(done && product == exp, tag, product, exp);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && product == 64'd0, "R1 reset", product, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && product == 64'd0, "R1 after reset", product, 64'd0);
    cmp_on = 1'b1;

    run_op(32'd2, 32'd6, 64'd12, "R9 2x6");
    run_op(32'hFFFF_FFF9, 32'd3, 64'hFFFF_FFFF_FFFF_FFEB, "R9 -7x3");
    run_op(32'h8000_0000, 32'h8000_0000, 64'h4000_0000_0000_0000, "R6 min x min");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 64'h0000_0000_8000_0000, "R6 min x -1");
    run_op(32'hFFFF_FFFF, 32'h8000_0000, 64'h0000_0000_8000_0000, "R6 -1 x min");
    run_op(32'h8000_0000, 32'h7FFF_FFFF, 64'hC000_0000_8000_0000, "R6 min x max");
    run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 64'h3FFF_FFFF_0000_0001, "R6 max x max");
    run_op(32'd0, 32'h8000_0000, 64'd0, "R6 zero x min");
    run_op(32'h1234_5678, 32'd0, 64'd0, "R6 x x zero");

    // R5: a second request mid-operation must be dropped
    start = 1'b1; mcand = 32'd5; mplier = 32'hFFFF_FFFD;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; mcand = 32'd1000; mplier = 32'd1000;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    chk(done && product == 64'hFFFF_FFFF_FFFF_FFF1, "R5 start while busy", product, 64'hFFFF_FFFF_FFFF_FFF1);
    @(negedge clk);

    // R7: idle with no request leaves the product alone
    repeat (5) @(negedge clk);
    chk(!busy && product == 64'hFFFF_FFFF_FFFF_FFF1, "R7 idle hold", product, 64'hFFFF_FFFF_FFFF_FFF1);

    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      ra = $urandom; rb = $urandom;
      run_op(ra, rb, ref_mul(ra, rb), "R4 random");
    end

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule